// File: doc/BRIEF.md
# Atomic 16-bit Timer Register Access Bridge

This block lets a CPU with an 8-bit data bus read and write a 16-bit free-running up-counter and a 16-bit compare/capture word without tearing. One shared staging byte holds the upper half of any 16-bit transfer. A write to an upper byte only fills the staging byte. The later write to the lower byte moves the staged byte and the new lower byte into the target together, in one edge. A read of a lower byte returns that byte and, on the same edge, copies the target's upper byte into the staging byte. The following upper-byte read returns that copy, which matches the lower byte even if the counter has moved on.

A control register has two mode bits. The width bit selects between plain 8-bit byte access and staged 16-bit access. The capture bit turns the compare word into a capture word, which a capture event loads from the counter. In staged mode the compare word is a fixed value that only the CPU changes, so it is read directly and its reads never touch the staging byte. The capture word changes behind the CPU's back, so its reads go through the staging byte. Every access is classified by a combinational access decoder. Read data is registered.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, the counter, the compare word, the staging byte, the control register (address 4) and `rdata` are all zero.
- R2: With control bit 0 (width) clear, each of addresses 0 (counter low), 1 (counter high), 2 (compare low) and 3 (compare high) behaves as an independent byte. A write changes only that byte, a read returns it, and the staging byte is left untouched.
- R3: With the width bit set, a write to address 1 or 3 loads only the staging byte, and the target word keeps its value.
- R4: With the width bit set, a write to address 0 or 2 loads {staging byte, written byte} into the target word on the same edge.
- R5: With the width bit set, a read of address 0 returns the counter's low byte and, on the same edge, loads the counter's high byte into the staging byte. A read of address 1 returns the staging byte, so the pair is coherent while the counter keeps counting.
- R6: With the width bit set and control bit 1 (capture) clear, reads of addresses 2 and 3 return the compare bytes directly and leave the staging byte unchanged.
- R7: With the capture bit set, a one-cycle `cap_evt` copies the counter into the compare/capture word. Reads of address 2 load the staging byte and reads of address 3 return it. With the capture bit clear, `cap_evt` has no effect.
- R8: The staging byte is shared. An upper-byte write to one register followed by an upper-byte write to the other, then a lower-byte write, commits the most recently staged byte.
- R9: The counter adds 1 on each edge with `cnt_en` high and wraps from 0xFFFF to 0x0000. A CPU write to a counter byte takes priority over the increment on that edge.
- R10: `rdata` changes only on the edge that samples a read (`rd_stb` high, `wr_stb` low), and then it shows the addressed value. It holds otherwise. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address (0 cnt lo, 1 cnt hi, 2 cmp lo, 3 cmp hi, 4 control) |
| wdata | input | 8 | Write data |
| wr_stb | input | 1 | Write strobe, one cycle per access; wins over `rd_stb` |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| cnt_en | input | 1 | Counter increment enable |
| cap_evt | input | 1 | Capture event pulse |
| rdata | output | 8 | Registered read data |

## Verification
The hardest case to reach is a torn read. The counter's low byte must wrap on the exact edge between the two byte reads, so that a naive read would pair an old low byte with a new high byte. The stimulus loads the counter with 0x12FF through a staged write while `cnt_en` is already high, which also exercises the write-over-increment priority. It then issues the low-byte and high-byte reads on the next two edges, so that the expected pair 0xFF/0x12 differs from the torn 0xFF/0x13. Staging-byte sharing is reached by interleaving upper-byte writes to both registers before a single lower-byte write.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    // Register addresses
    localparam int ADR_CNT_LO = 0;
    localparam int ADR_CNT_HI = 1;
    localparam int ADR_CMP_LO = 2;
    localparam int ADR_CMP_HI = 3;
    localparam int ADR_CTRL   = 4;

    // Control register bit positions
    localparam int CTRL_WIDE = 0;
    localparam int CTRL_CAP  = 1;
    localparam int CTRL_W    = 2;

    // Access kinds produced by the bus decoder
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_WR_LO,
        ACC_WR_HI,
        ACC_RD_LO,
        ACC_RD_HI,
        ACC_WR_CTRL,
        ACC_RD_CTRL,
        ACC_RD_VOID
    } acc_e;

endpackage

// File: rtl/bridge_decode.sv
module bridge_decode
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_stb,
    input  logic              rd_stb,
    output acc_e              acc,
    output logic              tgt_cmp
);

    always_comb begin
        acc     = ACC_NONE;
        tgt_cmp = 1'b0;
        if (wr_stb || rd_stb) begin
            unique case (addr)
                ADDR_W'(ADR_CNT_LO): acc = wr_stb ? ACC_WR_LO : ACC_RD_LO;
                ADDR_W'(ADR_CNT_HI): acc = wr_stb ? ACC_WR_HI : ACC_RD_HI;
                ADDR_W'(ADR_CMP_LO): begin
                    acc     = wr_stb ? ACC_WR_LO : ACC_RD_LO;
                    tgt_cmp = 1'b1;
                end
                ADDR_W'(ADR_CMP_HI): begin
                    acc     = wr_stb ? ACC_WR_HI : ACC_RD_HI;
                    tgt_cmp = 1'b1;
                end
                ADDR_W'(ADR_CTRL): acc = wr_stb ? ACC_WR_CTRL : ACC_RD_CTRL;
                default:           acc = wr_stb ? ACC_NONE : ACC_RD_VOID;
            endcase
        end
    end

endmodule

// File: rtl/stage_byte.sv
module stage_byte #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_val,
    output logic [BYTE_W-1:0] stage_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)       stage_q <= '0;
        else if (load_en) stage_q <= load_val;
    end

endmodule

// File: rtl/timer_core.sv
module timer_core #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_en,
    input  logic                cap_evt,
    input  logic                cap_mode,
    input  logic [1:0]          cnt_ben,
    input  logic [1:0]          cmp_ben,
    input  logic [2*BYTE_W-1:0] wval,
    output logic [2*BYTE_W-1:0] cnt_q,
    output logic [2*BYTE_W-1:0] cmp_q
);

    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] cnt_merge;
    logic [WORD_W-1:0] cmp_merge;

    // Byte-lane merge of CPU write data into each word
    for (genvar b = 0; b < 2; b++) begin : g_lane
        assign cnt_merge[b*BYTE_W +: BYTE_W] =
            cnt_ben[b] ? wval[b*BYTE_W +: BYTE_W] : cnt_q[b*BYTE_W +: BYTE_W];
        assign cmp_merge[b*BYTE_W +: BYTE_W] =
            cmp_ben[b] ? wval[b*BYTE_W +: BYTE_W] : cmp_q[b*BYTE_W +: BYTE_W];
    end

    // CPU write wins over increment and over capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else begin
            if (|cnt_ben)    cnt_q <= cnt_merge;
            else if (cnt_en) cnt_q <= cnt_q + WORD_W'(1);

            if (|cmp_ben)                cmp_q <= cmp_merge;
            else if (cap_mode && cap_evt) cmp_q <= cnt_q;
        end
    end

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              cnt_en,
    input  logic              cap_evt,
    output logic [BYTE_W-1:0] rdata
);

    localparam int WORD_W = 2 * BYTE_W;

    acc_e              acc;
    logic              tgt_cmp;
    logic [CTRL_W-1:0] ctrl_q;
    logic              wide, cap_mode, via_stage;
    logic [BYTE_W-1:0] tmp_q;
    logic              tmp_load;
    logic [BYTE_W-1:0] tmp_val;
    logic [WORD_W-1:0] cnt_q, cmp_q, tgt_word;
    logic [1:0]        ben, cnt_ben, cmp_ben;
    logic [WORD_W-1:0] wval;
    logic [BYTE_W-1:0] rd_nxt;
    logic              rd_take;

    assign wide      = ctrl_q[CTRL_WIDE];
    assign cap_mode  = ctrl_q[CTRL_CAP];
    assign via_stage = wide && (!tgt_cmp || cap_mode);
    assign tgt_word  = tgt_cmp ? cmp_q : cnt_q;

    bridge_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (addr),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .acc     (acc),
        .tgt_cmp (tgt_cmp)
    );

    stage_byte #(.BYTE_W(BYTE_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (tmp_load),
        .load_val (tmp_val),
        .stage_q  (tmp_q)
    );

    timer_core #(.BYTE_W(BYTE_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .cap_evt  (cap_evt),
        .cap_mode (cap_mode),
        .cnt_ben  (cnt_ben),
        .cmp_ben  (cmp_ben),
        .wval     (wval),
        .cnt_q    (cnt_q),
        .cmp_q    (cmp_q)
    );

    // Write steering and staging-byte control
    always_comb begin
        ben      = 2'b00;
        wval     = {wdata, wdata};
        tmp_load = 1'b0;
        tmp_val  = wdata;
        unique case (acc)
            ACC_WR_LO: begin
                ben  = wide ? 2'b11 : 2'b01;
                wval = wide ? {tmp_q, wdata} : {wdata, wdata};
            end
            ACC_WR_HI: begin
                ben      = wide ? 2'b00 : 2'b10;
                tmp_load = wide;
            end
            ACC_RD_LO: begin
                tmp_load = via_stage;
                tmp_val  = tgt_word[WORD_W-1:BYTE_W];
            end
            default: ;
        endcase
        cnt_ben = tgt_cmp ? 2'b00 : ben;
        cmp_ben = tgt_cmp ? ben : 2'b00;
    end

    // Read data selection
    always_comb begin
        rd_take = 1'b1;
        rd_nxt  = '0;
        unique case (acc)
            ACC_RD_LO:   rd_nxt = tgt_word[BYTE_W-1:0];
            ACC_RD_HI:   rd_nxt = via_stage ? tmp_q : tgt_word[WORD_W-1:BYTE_W];
            ACC_RD_CTRL: rd_nxt = BYTE_W'(ctrl_q);
            ACC_RD_VOID: rd_nxt = '0;
            default:     rd_take = 1'b0;
        endcase
    end

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)                 ctrl_q <= '0;
        else if (acc == ACC_WR_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
    end

    // Registered read data output
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (rd_take) rdata <= rd_nxt;
    end

endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
    parameter int ADDR_W = 3,
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic [BYTE_W-1:0]   wdata,
    input logic                wr_stb,
    input logic                rd_stb,
    input logic                cnt_en,
    input logic [BYTE_W-1:0]   rdata,
    input logic [2*BYTE_W-1:0] cnt_q,
    input logic [BYTE_W-1:0]   tmp_q,
    input logic [1:0]          ctrl_q
);

    localparam int WORD_W = 2 * BYTE_W;

    // R3: staged high write leaves the counter to its own counting
    a_r3_hi_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr == ADDR_W'(1) && ctrl_q[0])
        |=> cnt_q == $past(cnt_q) + WORD_W'($past(cnt_en)));

    // R4: low write commits staged byte and written byte together
    a_r4_lo_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr == ADDR_W'(0) && ctrl_q[0])
        |=> cnt_q == $past({tmp_q, wdata}));

    // R5: low read snapshots the high half into the staging byte
    a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && addr == ADDR_W'(0) && ctrl_q[0])
        |=> tmp_q == $past(cnt_q[WORD_W-1:BYTE_W]));

    // R6: compare low read bypasses the staging byte
    a_r6_cmp_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && addr == ADDR_W'(2) && ctrl_q == 2'b01)
        |=> $stable(tmp_q));

    // R9: increment by one when no CPU write hits the counter
    a_r9_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !(wr_stb && addr < ADDR_W'(2)))
        |=> cnt_q == $past(cnt_q) + WORD_W'(1));

    // R10: read data holds unless a read is sampled
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb || wr_stb) |=> $stable(rdata));

endmodule

bind wide_reg_bridge bridge_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wdata  (wdata),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .cnt_en (cnt_en),
    .rdata  (rdata),
    .cnt_q  (cnt_q),
    .tmp_q  (tmp_q),
    .ctrl_q (ctrl_q)
);

// File: tb/sim_wide_reg_bridge.sv
module sim_wide_reg_bridge;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_stb = 1'b0;
    logic       rd_stb = 1'b0;
    logic       cnt_en = 1'b0;
    logic       cap_evt = 1'b0;
    logic [7:0] rdata;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;  // 250 MHz

    wide_reg_bridge u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .cnt_en  (cnt_en),
        .cap_evt (cap_evt),
        .rdata   (rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Drivers: called at a falling edge, return at the next falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        e.val = exp; e.tag = tag;
        sb.push_back(e);
        addr = a; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    // Monitor: rdata is valid at the falling edge after the sampling edge
    logic rd_seen = 1'b0;
    always @(posedge clk) rd_seen <= rd_stb && !wr_stb;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL R10: unexpected read data %02h expected none", rdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, rdata, e.val);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(3'd4, 8'h00, "R1 ctrl");
        rd(3'd0, 8'h00, "R1 cnt lo");
        rd(3'd1, 8'h00, "R1 cnt hi");
        rd(3'd2, 8'h00, "R1 cmp lo");
        rd(3'd3, 8'h00, "R1 cmp hi");

        // R2: narrow byte access, staging byte untouched
        wr(3'd0, 8'hA5);
        wr(3'd3, 8'h3C);
        rd(3'd0, 8'hA5, "R2 cnt lo");
        rd(3'd1, 8'h00, "R2 cnt hi");
        rd(3'd3, 8'h3C, "R2 cmp hi");
        rd(3'd2, 8'h00, "R2 cmp lo");
        wr(3'd4, 8'h01);
        rd(3'd4, 8'h01, "R2 ctrl wide");
        wr(3'd0, 8'h77);                 // staging still 00
        rd(3'd0, 8'h77, "R2 cnt lo");
        rd(3'd1, 8'h00, "R2 staging untouched");

        // R3: staged high write leaves targets unchanged
        wr(3'd1, 8'hBE);
        rd(3'd3, 8'h3C, "R3 cmp unchanged");
        rd(3'd0, 8'h77, "R3 cnt lo");
        rd(3'd1, 8'h00, "R3 cnt hi unchanged");

        // R4: low write commits the pair
        wr(3'd1, 8'hBE);
        wr(3'd0, 8'hEF);
        rd(3'd0, 8'hEF, "R4 cnt lo");
        rd(3'd1, 8'hBE, "R4 cnt hi");

        // R6: compare read is direct, does not disturb staging
        wr(3'd3, 8'hC0);
        wr(3'd2, 8'hDE);
        rd(3'd0, 8'hEF, "R6 cnt lo");    // staging = BE
        rd(3'd2, 8'hDE, "R6 cmp lo");
        rd(3'd3, 8'hC0, "R6 cmp hi direct");
        rd(3'd1, 8'hBE, "R6 staging kept");

        // R8: shared staging byte, interleaved high writes
        wr(3'd3, 8'h11);
        wr(3'd1, 8'h22);
        wr(3'd2, 8'h33);
        wr(3'd0, 8'h44);
        rd(3'd2, 8'h33, "R8 cmp lo");
        rd(3'd3, 8'h22, "R8 cmp hi takes last staged");
        rd(3'd0, 8'h44, "R8 cnt lo");
        rd(3'd1, 8'h22, "R8 cnt hi");

        // R7: capture ignored while capture mode is off
        cap_evt = 1'b1;
        @(negedge clk);
        cap_evt = 1'b0;
        rd(3'd2, 8'h33, "R7 no capture lo");
        rd(3'd3, 8'h22, "R7 no capture hi");

        // R5 + R9: coherent read across a carry, write beats increment
        wr(3'd1, 8'h12);
        cnt_en = 1'b1;
        wr(3'd0, 8'hFF);                 // cnt = 12FF despite cnt_en
        rd(3'd0, 8'hFF, "R9 write priority / R5 lo");   // cnt -> 1300
        rd(3'd1, 8'h12, "R5 coherent hi");              // cnt -> 1301
        cnt_en = 1'b0;
        rd(3'd0, 8'h01, "R9 count lo");
        rd(3'd1, 8'h13, "R9 count hi");

        // R7: capture mode reads through staging byte
        wr(3'd4, 8'h03);
        cap_evt = 1'b1;
        @(negedge clk);
        cap_evt = 1'b0;                  // capture = 1301
        wr(3'd1, 8'hAA);
        wr(3'd0, 8'hBB);
        rd(3'd2, 8'h01, "R7 cap lo");
        rd(3'd3, 8'h13, "R7 cap hi");
        rd(3'd2, 8'h01, "R7 cap lo again");
        rd(3'd0, 8'hBB, "R7 cnt lo");    // staging = AA
        rd(3'd3, 8'hAA, "R7 cap hi via staging");

        // R10: hold across idle cycles and a write
        repeat (3) @(negedge clk);
        chk("R10 hold idle", rdata, 8'hAA);
        wr(3'd4, 8'h03);
        chk("R10 hold on write", rdata, 8'hAA);
        rd(3'd6, 8'h00, "R10 unmapped");

        // R9: wrap
        wr(3'd4, 8'h00);
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        cnt_en = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0;
        rd(3'd0, 8'h00, "R9 wrap lo");
        rd(3'd1, 8'h00, "R9 wrap hi");

        repeat (2) @(negedge clk);
        if (sb.size() != 0) begin
            checks++; fails++;
            $display("FAIL R10: pending reads %0d expected 0", sb.size());
        end
        summary();
        $finish;
    end

endmodule